// File: doc/BRIEF.md
# Post-Reset Clock Start-up Sequencer

This block decides when the processor core may start executing instructions after a reset. Any of several reset sources restarts the same sequence. The sequence puts the system clock selection back to the primary clock. In crystal modes it counts primary-clock cycles until the oscillator can be trusted. In parallel, it can run a CPU wake-up delay on the fast internal clock. The core stays frozen in the first phase of its four-phase instruction cycle until the sequence releases it.

The primary-clock count is made in the primary-clock domain. Its completion crosses into the fast-clock domain through two flip-flops. There it is combined with the CPU delay, and hold is released one fast-clock cycle after both have finished. When two-speed start-up is enabled, the system runs from the internal RC clock until the crystal count completes.

Top module: `startup_seq`

## Requirements
- R1: While any bit of `rst_src` is high, `hold` is 1, `q_phase` is 00 (first phase) and `clk_sel` is 00 (primary clock).
- R2: Each reset source bit used alone produces the same release timing for the same configuration.
- R3: In crystal modes (`osc_mode` 0 = low-power, 1 = standard, 2 = high-speed), `osc_ok` is 0 during reset and becomes 1 no earlier than OSC_CYCLES primary-clock rising edges after reset release, and at most one primary-clock edge later than that.
- R4: In non-crystal modes (`osc_mode` 3 = RC, 4 = external clock, 5 = internal RC, 6 and 7 treated alike), `osc_ok` is 1 at all times, including during reset.
- R5: If `asleep` is high during reset, the CPU delay lasts CPU_DLY fast-clock edges after release. Otherwise it counts as finished at the first edge. Hold is never released before this delay has finished.
- R6: `hold` falls on the fast-clock edge that follows the first edge at which both `osc_ok` and the CPU delay are complete.
- R7: While `hold` is 1, `q_phase` stays 00. After `hold` falls, `q_phase` advances by one on each fast-clock edge and wraps from 11 to 00.
- R8: `clk_sel` is 10 (internal RC) when `two_speed` is 1, the mode is a crystal mode, no reset is active and `osc_ok` is 0. Otherwise it is 00. No other code appears.
- R9: Once high, `osc_ok` stays high, and once low, `hold` stays low, until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Primary oscillator clock |
| fclk | input | 1 | Fast internal clock; sequencer and core-hold domain |
| rst_src | input | NSRC | Reset requests, one bit per source, active high |
| osc_mode | input | 3 | Configured primary oscillator mode |
| two_speed | input | 1 | Enables running from the internal clock during start-up |
| asleep | input | 1 | Device was in sleep when the reset arrived |
| hold | output | 1 | Core held in first phase, execution suspended |
| clk_sel | output | 2 | System clock select: 00 primary, 10 internal RC |
| q_phase | output | 2 | Instruction-cycle phase, 00 = first phase |
| osc_ok | output | 1 | Primary oscillator considered stable |

## Verification
The assertions assume that `osc_mode`, `two_speed` and `asleep` stay constant between resets. They also assume that each reset request lasts long enough to be seen by at least two edges of both clocks, because both domains sample `rst_src` synchronously. The bench changes the configuration only while a reset is asserted and holds every reset for eight fast-clock cycles, which covers more than two primary-clock edges. The two clocks run at unrelated phase offsets, so the crossing of the count-complete signal is exercised without any edge landing at the same instant as a sampling point.

// File: rtl/sus_pkg.sv
package sus_pkg;

    typedef enum logic [2:0] {
        MODE_XLP   = 3'd0,
        MODE_XSTD  = 3'd1,
        MODE_XHS   = 3'd2,
        MODE_RC    = 3'd3,
        MODE_EXT   = 3'd4,
        MODE_INTRC = 3'd5
    } osc_mode_e;

    typedef enum logic [1:0] {
        SEL_PRIMARY  = 2'b00,
        SEL_INTERNAL = 2'b10
    } clk_sel_e;

    typedef struct packed {
        logic osc_done;
        logic cpu_done;
    } start_status_t;

    function automatic logic is_crystal(input logic [2:0] mode);
        return (mode < 3'd3);
    endfunction

endpackage

// File: rtl/sus_osc_counter.sv
module sus_osc_counter #(
    parameter int LIMIT = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic done
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (en && !done) begin
            if (cnt == CW'(LIMIT - 1)) begin
                done <= 1'b1;
            end
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/sus_sync2.sv
module sus_sync2 (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= 1'b0;
            q    <= 1'b0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/sus_cpu_timer.sv
module sus_cpu_timer #(
    parameter int DLY = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic arm_in,
    output logic done
);
    localparam int CW = (DLY > 1) ? $clog2(DLY) : 1;

    logic [CW-1:0] cnt;
    logic          armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= arm_in;
            cnt   <= '0;
            done  <= 1'b0;
        end else if (!done) begin
            if (!armed || cnt == CW'(DLY - 1)) begin
                done <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sus_phase_gen.sv
module sus_phase_gen (
    input  logic       clk,
    input  logic       rst,
    input  logic       freeze,
    output logic [1:0] phase
);
    always_ff @(posedge clk) begin
        if (rst || freeze) begin
            phase <= 2'b00;
        end else begin
            phase <= phase + 2'b01;
        end
    end
endmodule

// File: rtl/startup_seq.sv
module startup_seq #(
    parameter int NSRC       = 4,
    parameter int OSC_CYCLES = 1024,
    parameter int CPU_DLY    = 64
) (
    input  logic            pclk,
    input  logic            fclk,
    input  logic [NSRC-1:0] rst_src,
    input  logic [2:0]      osc_mode,
    input  logic            two_speed,
    input  logic            asleep,
    output logic            hold,
    output logic [1:0]      clk_sel,
    output logic [1:0]      q_phase,
    output logic            osc_ok
);
    import sus_pkg::*;

    logic          rst_any;
    logic          xtal;
    logic          osc_done_p;
    logic          osc_sync;
    logic          cpu_done;
    logic          rel_q;
    start_status_t st;
    clk_sel_e      sel;

    assign rst_any = |rst_src;
    assign xtal    = is_crystal(osc_mode);

    sus_osc_counter #(.LIMIT(OSC_CYCLES)) u_osc (
        .clk  (pclk),
        .rst  (rst_any),
        .en   (xtal),
        .done (osc_done_p)
    );

    sus_sync2 u_sync (
        .clk (fclk),
        .rst (rst_any),
        .d   (osc_done_p),
        .q   (osc_sync)
    );

    sus_cpu_timer #(.DLY(CPU_DLY)) u_cpu (
        .clk    (fclk),
        .rst    (rst_any),
        .arm_in (asleep),
        .done   (cpu_done)
    );

    assign st.osc_done = ~xtal | osc_sync;
    assign st.cpu_done = cpu_done;

    always_ff @(posedge fclk) begin
        if (rst_any) begin
            rel_q <= 1'b0;
        end else if (st.osc_done && st.cpu_done) begin
            rel_q <= 1'b1;
        end
    end

    assign hold = ~rel_q;

    sus_phase_gen u_phase (
        .clk    (fclk),
        .rst    (rst_any),
        .freeze (hold),
        .phase  (q_phase)
    );

    always_comb begin
        if (!rst_any && two_speed && xtal && !osc_sync) begin
            sel = SEL_INTERNAL;
        end else begin
            sel = SEL_PRIMARY;
        end
    end

    assign clk_sel = sel;
    assign osc_ok  = st.osc_done;

endmodule

// File: rtl/startup_seq_chk.sv
module startup_seq_chk #(
    parameter int NSRC = 4
) (
    input logic            fclk,
    input logic [NSRC-1:0] rst_src,
    input logic [2:0]      osc_mode,
    input logic            two_speed,
    input logic            hold,
    input logic [1:0]      clk_sel,
    input logic [1:0]      q_phase,
    input logic            osc_ok
);
    logic rst_any;
    logic xtal;
    assign rst_any = |rst_src;
    assign xtal    = sus_pkg::is_crystal(osc_mode);

    assert_frozen_q1_R7: assert property (@(posedge fclk) disable iff (rst_any)
        hold |-> (q_phase == 2'b00));

    assert_phase_step_R7: assert property (@(posedge fclk) disable iff (rst_any)
        !hold |=> (q_phase == $past(q_phase) + 2'b01));

    assert_osc_sticky_R9: assert property (@(posedge fclk) disable iff (rst_any)
        osc_ok |=> osc_ok);

    assert_hold_sticky_R9: assert property (@(posedge fclk) disable iff (rst_any)
        !hold |=> !hold);

    assert_release_after_osc_R6: assert property (@(posedge fclk) disable iff (rst_any)
        $fell(hold) |-> $past(osc_ok));

    assert_sel_internal_R8: assert property (@(posedge fclk) disable iff (rst_any)
        (clk_sel != 2'b00) |-> (two_speed && xtal && !osc_ok));

    assert_sel_codes_R8: assert property (@(posedge fclk) disable iff (rst_any)
        (clk_sel == 2'b00) || (clk_sel == 2'b10));

    assert_nonxtal_stable_R4: assert property (@(posedge fclk) disable iff (rst_any)
        !xtal |-> osc_ok);

endmodule

bind startup_seq startup_seq_chk #(.NSRC(NSRC)) u_chk (
    .fclk      (fclk),
    .rst_src   (rst_src),
    .osc_mode  (osc_mode),
    .two_speed (two_speed),
    .hold      (hold),
    .clk_sel   (clk_sel),
    .q_phase   (q_phase),
    .osc_ok    (osc_ok)
);

// File: tb/sim_startup_seq.sv
module sim_startup_seq;
    localparam int FPER  = 10;
    localparam int PHALF = 15;
    localparam int NSRC  = 3;
    localparam int NOSC  = 16;
    localparam int NCPU  = 12;
    localparam int LOOP  = NOSC * 3 + NCPU + 30;

    logic            pclk = 1'b0;
    logic            fclk = 1'b0;
    logic [NSRC-1:0] rst_src = '1;
    logic [2:0]      osc_mode = 3'd0;
    logic            two_speed = 1'b0;
    logic            asleep = 1'b0;
    logic            hold;
    logic [1:0]      clk_sel;
    logic [1:0]      q_phase;
    logic            osc_ok;

    int checks = 0;
    int errors = 0;
    int pc = 0;
    bit done_flag = 1'b0;

    startup_seq #(.NSRC(NSRC), .OSC_CYCLES(NOSC), .CPU_DLY(NCPU)) u0 (
        .pclk(pclk), .fclk(fclk), .rst_src(rst_src), .osc_mode(osc_mode),
        .two_speed(two_speed), .asleep(asleep), .hold(hold),
        .clk_sel(clk_sel), .q_phase(q_phase), .osc_ok(osc_ok)
    );

    always #(FPER / 2) fclk = ~fclk;
    initial begin
        #2;
        forever #(PHALF) pclk = ~pclk;
    end

    always @(posedge pclk) begin
        if (|rst_src) pc <= 0;
        else          pc <= pc + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (mode=%0d ts=%0b sleep=%0b)",
                     req, act, exp, osc_mode, two_speed, asleep);
        end
    endtask

    task automatic run(input int mode, input bit ts, input bit slp, input int src, inout int ref_fc);
        bit xt;
        int k_ok, pc_ok, hold_fc, cpu_e, exp_fc;
        int bad_ph, bad_sel, bad_stk, bad_nx;
        bit prev_ok, prev_hold;
        xt = (mode < 3);
        @(negedge fclk);
        rst_src   = NSRC'(1) << src;
        osc_mode  = 3'(mode);
        two_speed = ts;
        asleep    = slp;
        repeat (8) @(negedge fclk);
        // R1 reset state
        chk(hold == 1'b1 && q_phase == 2'b00 && clk_sel == 2'b00, "R1",
            {hold, q_phase, clk_sel}, 5'b10000);
        // R3 / R4 oscillator flag during reset
        chk(osc_ok == !xt, xt ? "R3" : "R4", osc_ok, !xt);
        rst_src = '0;
        k_ok = xt ? -1 : 0; pc_ok = -1; hold_fc = -1;
        bad_ph = 0; bad_sel = 0; bad_stk = 0; bad_nx = 0;
        prev_ok = osc_ok; prev_hold = 1'b1;
        for (int i = 1; i <= LOOP; i++) begin
            @(negedge fclk);
            if (osc_ok && k_ok < 0) begin k_ok = i; pc_ok = pc; end
            if (!hold && hold_fc < 0) hold_fc = i;
            if (!xt && !osc_ok) bad_nx++;
            if ((prev_ok && !osc_ok) || (!prev_hold && hold)) bad_stk++;
            if (clk_sel != ((ts && xt && !osc_ok) ? 2'b10 : 2'b00)) bad_sel++;
            if (hold_fc >= 0) begin
                if (q_phase != 2'((i - hold_fc) % 4)) bad_ph++;
            end else if (q_phase != 2'b00) bad_ph++;
            prev_ok = osc_ok; prev_hold = hold;
        end
        cpu_e = slp ? NCPU : 1;
        if (xt) begin
            chk(pc_ok >= NOSC && pc_ok <= NOSC + 1, "R3", pc_ok, NOSC);
        end else begin
            chk(bad_nx == 0, "R4", bad_nx, 0);
        end
        chk(hold_fc >= cpu_e + 1, "R5", hold_fc, cpu_e + 1);
        exp_fc = ((k_ok > cpu_e) ? k_ok : cpu_e) + 1;
        chk(hold_fc == exp_fc, "R6", hold_fc, exp_fc);
        chk(bad_ph == 0, "R7", bad_ph, 0);
        chk(bad_sel == 0, "R8", bad_sel, 0);
        chk(bad_stk == 0, "R9", bad_stk, 0);
        if (src == 0) ref_fc = hold_fc;
        else chk(hold_fc == ref_fc, "R2", hold_fc, ref_fc);
    endtask

    initial begin
        #(200000 * FPER);
        if (!done_flag) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int ref_fc;
        ref_fc = -1;
        for (int m = 0; m < 8; m++)
            for (int t = 0; t < 2; t++)
                for (int s = 0; s < 2; s++)
                    for (int r = 0; r < NSRC; r++)
                        run(m, t[0], s[0], r, ref_fc);
        done_flag = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule